// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. The datapath has one memory shared by instructions and data, one ALU, and holding registers between steps. The sequencer reads the 6-bit opcode field of the instruction register. It then steps through one control state per clock and drives every enable and select that the datapath needs in that step.

Every instruction starts with a shared fetch step and a shared decode step. After that it takes a path that depends on its class:

| Class | Total steps |
|---|---|
| load | five |
| store | four |
| register-register arithmetic | four |
| branch-if-equal | three |
| jump | three |

All control outputs are decoded from the registered step alone, so they are glitch-free for the whole cycle.

The current step index is brought out as well. The surrounding datapath and test logic can use it to see how far an instruction has progressed.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in step 0 (fetch) at the next rising edge. This holds regardless of the step it was in.
- R2: Step 0 asserts memory read, instruction-register load and PC write. It selects the PC as the memory address, the PC as ALU operand A, constant 4 as operand B (B select 01) and the add mode (ALU mode 00). It also selects PC source 00. Step 0 always moves to step 1.
- R3: Step 1 selects the PC as operand A, the shifted sign-extended immediate as operand B (B select 11) and the add mode. It asserts no enable.
- R4: From step 1 the next step is 2 for load (100011) and store (101011). It is 6 for register-register (000000), 8 for branch-if-equal (000100) and 9 for jump (000010).
- R5: Step 2 selects the register as operand A, the sign-extended immediate as operand B (B select 10) and the add mode. It then goes to step 3 for a load, to step 5 for a store, and to step 0 for any other opcode.
- R6: Step 3 asserts memory read with the ALU result as address and goes to step 4. Step 4 writes the register file from memory data into the rt field (destination select 0) and returns to step 0. A load therefore takes 5 cycles.
- R7: Step 5 asserts memory write with the ALU result as address and returns to step 0. A store therefore takes 4 cycles.
- R8: Step 6 selects the register as operand A, register B as operand B (B select 00) and the function-field mode (ALU mode 10), then goes to step 7. Step 7 writes the ALU result into the rd field (data select 0, destination select 1) and returns to step 0.
- R9: Step 8 selects the register as operand A, register B as operand B and subtract (ALU mode 01). It selects PC source 01, asserts the conditional PC write, and returns to step 0.
- R10: Step 9 selects PC source 10 (jump target), asserts PC write and returns to step 0.
- R11: An opcode outside the five recognised values, seen in step 1, returns the sequencer to step 0.
- R12: Any control not named for a step is 0 in that step. PC write is 1 only in steps 0 and 9. Conditional PC write is 1 only in step 8. The ALU address select is 1 only in steps 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| step_o | output | 4 | Current step index 0..9 |
| mem_rd_en | output | 1 | Memory read |
| mem_wr_en | output | 1 | Memory write |
| addr_from_alu | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| instr_ld_en | output | 1 | Load instruction register from memory |
| pc_wr_en | output | 1 | Unconditional PC write |
| pc_wr_if_zero | output | 1 | PC write when the ALU zero flag is set |
| pc_src_sel | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_a_from_reg | output | 1 | Operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | Operand B: 00 reg B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 function field |
| rf_wr_en | output | 1 | Register file write |
| rf_data_from_mem | output | 1 | Write data: 0 = ALU result register, 1 = memory data register |
| rf_dst_is_rd | output | 1 | Destination: 0 = rt field, 1 = rd field |

## Verification
All outputs depend only on the step register, so a wrong step shows up within one clock as a wrong control word, such as a stray memory write or a PC update at the wrong moment. A dispatch fault in step 1 or step 2 shows in the very next cycle, because the step index and the operand selects both change.

A missing return to fetch appears as a missing instruction-register load on the cycle when a new instruction should begin. That stretches or shortens the cycle counts for each instruction class.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int STEP_W = 4;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LD_RD  = 4'd3,
    ST_LD_WB  = 4'd4,
    ST_ST_WR  = 4'd5,
    ST_R_EXE  = 4'd6,
    ST_R_WB   = 4'd7,
    ST_BEQ    = 4'd8,
    ST_JMP    = 4'd9
  } step_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_alu;
    logic       ir_ld;
    logic       pc_wr;
    logic       pc_cond;
    logic [1:0] pc_src;
    logic       a_reg;
    logic [1:0] b_sel;
    logic [1:0] mode;
    logic       rf_wr;
    logic       rf_mem;
    logic       rf_rd;
  } ctrl_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int              OPC_W = 6,
  parameter logic [OPC_W-1:0] OP_RT = 6'b000000,
  parameter logic [OPC_W-1:0] OP_LW = 6'b100011,
  parameter logic [OPC_W-1:0] OP_SW = 6'b101011,
  parameter logic [OPC_W-1:0] OP_BQ = 6'b000100,
  parameter logic [OPC_W-1:0] OP_JP = 6'b000010
) (
  input  step_e            cur,
  input  logic [OPC_W-1:0] opc,
  output step_e            nxt,
  output logic             opc_known
);

  function automatic step_e class_dispatch(input logic [OPC_W-1:0] o);
    if (o == OP_LW || o == OP_SW) return ST_ADDR;
    if (o == OP_RT)               return ST_R_EXE;
    if (o == OP_BQ)               return ST_BEQ;
    if (o == OP_JP)               return ST_JMP;
    return ST_FETCH;
  endfunction

  function automatic step_e mem_dispatch(input logic [OPC_W-1:0] o);
    if (o == OP_LW) return ST_LD_RD;
    if (o == OP_SW) return ST_ST_WR;
    return ST_FETCH;
  endfunction

  assign opc_known = (opc == OP_RT) || (opc == OP_LW) || (opc == OP_SW) ||
                     (opc == OP_BQ) || (opc == OP_JP);

  always_comb begin
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = class_dispatch(opc);
      ST_ADDR:   nxt = mem_dispatch(opc);
      ST_LD_RD:  nxt = ST_LD_WB;
      ST_R_EXE:  nxt = ST_R_WB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  step_e cur,
  output ctrl_t ctl
);

  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_ld  = 1'b1;
        ctl.b_sel  = 2'b01;
        ctl.pc_wr  = 1'b1;
      end
      ST_DECODE: ctl.b_sel = 2'b11;
      ST_ADDR: begin
        ctl.a_reg = 1'b1;
        ctl.b_sel = 2'b10;
      end
      ST_LD_RD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      ST_LD_WB: begin
        ctl.rf_wr  = 1'b1;
        ctl.rf_mem = 1'b1;
      end
      ST_ST_WR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      ST_R_EXE: begin
        ctl.a_reg = 1'b1;
        ctl.mode  = 2'b10;
      end
      ST_R_WB: begin
        ctl.rf_wr = 1'b1;
        ctl.rf_rd = 1'b1;
      end
      ST_BEQ: begin
        ctl.a_reg   = 1'b1;
        ctl.mode    = 2'b01;
        ctl.pc_src  = 2'b01;
        ctl.pc_cond = 1'b1;
      end
      ST_JMP: begin
        ctl.pc_src = 2'b10;
        ctl.pc_wr  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int               OPC_W = 6,
  parameter logic [OPC_W-1:0] OP_RT = 6'b000000,
  parameter logic [OPC_W-1:0] OP_LW = 6'b100011,
  parameter logic [OPC_W-1:0] OP_SW = 6'b101011,
  parameter logic [OPC_W-1:0] OP_BQ = 6'b000100,
  parameter logic [OPC_W-1:0] OP_JP = 6'b000010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [3:0]       step_o,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic             addr_from_alu,
  output logic             instr_ld_en,
  output logic             pc_wr_en,
  output logic             pc_wr_if_zero,
  output logic [1:0]       pc_src_sel,
  output logic             alu_a_from_reg,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_mode,
  output logic             rf_wr_en,
  output logic             rf_data_from_mem,
  output logic             rf_dst_is_rd
);

  step_e step_q, step_d;
  ctrl_t ctl;
  logic  opc_known;

  mc_ctrl_next #(
    .OPC_W(OPC_W), .OP_RT(OP_RT), .OP_LW(OP_LW),
    .OP_SW(OP_SW), .OP_BQ(OP_BQ), .OP_JP(OP_JP)
  ) u_next (
    .cur(step_q), .opc(opcode), .nxt(step_d), .opc_known(opc_known)
  );

  mc_ctrl_decode u_dec (.cur(step_q), .ctl(ctl));

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_FETCH;
    else     step_q <= step_d;
  end

  // Named events for the assertions
  logic in_decode, in_ld_rd, in_terminal;
  assign in_decode   = (step_q == ST_DECODE);
  assign in_ld_rd    = (step_q == ST_LD_RD);
  assign in_terminal = (step_q == ST_LD_WB) || (step_q == ST_ST_WR) ||
                       (step_q == ST_R_WB)  || (step_q == ST_BEQ)   ||
                       (step_q == ST_JMP);

  assign step_o           = step_q;
  assign mem_rd_en        = ctl.mem_rd;
  assign mem_wr_en        = ctl.mem_wr;
  assign addr_from_alu    = ctl.addr_alu;
  assign instr_ld_en      = ctl.ir_ld;
  assign pc_wr_en         = ctl.pc_wr;
  assign pc_wr_if_zero    = ctl.pc_cond;
  assign pc_src_sel       = ctl.pc_src;
  assign alu_a_from_reg   = ctl.a_reg;
  assign alu_b_sel        = ctl.b_sel;
  assign alu_mode         = ctl.mode;
  assign rf_wr_en         = ctl.rf_wr;
  assign rf_data_from_mem = ctl.rf_mem;
  assign rf_dst_is_rd     = ctl.rf_rd;

  a_r1_reset_to_fetch: assert property (@(posedge clk)
    rst |=> step_o == 4'd0);

  a_r11_unknown_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (in_decode && !opc_known) |=> step_o == 4'd0);

  a_r4_rtype_dispatch: assert property (@(posedge clk) disable iff (rst)
    (in_decode && opcode == OP_RT) |=> step_o == 4'd6);

  a_r6_load_writeback: assert property (@(posedge clk) disable iff (rst)
    in_ld_rd |=> (rf_wr_en && rf_data_from_mem && !rf_dst_is_rd));

  a_r12_last_step_returns: assert property (@(posedge clk) disable iff (rst)
    in_terminal |=> instr_ld_en);

  a_r12_single_mem_access: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  a_r12_one_pc_update_kind: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr_en && pc_wr_if_zero));

endmodule

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;

  localparam logic [5:0] C_RT = 6'b000000;
  localparam logic [5:0] C_LW = 6'b100011;
  localparam logic [5:0] C_SW = 6'b101011;
  localparam logic [5:0] C_BQ = 6'b000100;
  localparam logic [5:0] C_JP = 6'b000010;
  localparam logic [5:0] C_XX = 6'b111111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] step_o;
  logic mem_rd_en, mem_wr_en, addr_from_alu, instr_ld_en, pc_wr_en, pc_wr_if_zero;
  logic [1:0] pc_src_sel, alu_b_sel, alu_mode;
  logic alu_a_from_reg, rf_wr_en, rf_data_from_mem, rf_dst_is_rd;

  always #4 clk = ~clk;

  mc_ctrl_fsm u_mc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .step_o(step_o),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .addr_from_alu(addr_from_alu),
    .instr_ld_en(instr_ld_en), .pc_wr_en(pc_wr_en), .pc_wr_if_zero(pc_wr_if_zero),
    .pc_src_sel(pc_src_sel), .alu_a_from_reg(alu_a_from_reg), .alu_b_sel(alu_b_sel),
    .alu_mode(alu_mode), .rf_wr_en(rf_wr_en), .rf_data_from_mem(rf_data_from_mem),
    .rf_dst_is_rd(rf_dst_is_rd)
  );

  int n_vec = 0;
  int n_bad = 0;
  int model = 0;
  int prior = 0;
  bit was_rst = 1'b0;
  bit done = 1'b0;

  // Expected control word for a step, packed as:
  // {rd, wr, addr, ir, pcw, pcc, pcsrc[2], a, b[2], mode[2], rfw, rfm, rfd}
  function automatic logic [15:0] want(int s);
    bit rd, wr, ad, ir, pw, pc, aa, rw, rm, dd;
    bit [1:0] ps, bs, md;
    {rd, wr, ad, ir, pw, pc, aa, rw, rm, dd} = '0;
    ps = 2'b00; bs = 2'b00; md = 2'b00;
    if (s == 0) begin rd = 1; ir = 1; pw = 1; bs = 2'b01; end
    if (s == 1) bs = 2'b11;
    if (s == 2) begin aa = 1; bs = 2'b10; end
    if (s == 3 || s == 5) ad = 1;
    if (s == 3) rd = 1;
    if (s == 5) wr = 1;
    if (s == 4 || s == 7) rw = 1;
    if (s == 4) rm = 1;
    if (s == 7) dd = 1;
    if (s == 6 || s == 8) aa = 1;
    if (s == 6) md = 2'b10;
    if (s == 8) begin md = 2'b01; ps = 2'b01; pc = 1; end
    if (s == 9) begin ps = 2'b10; pw = 1; end
    return {rd, wr, ad, ir, pw, pc, ps, aa, bs, md, rw, rm, dd};
  endfunction

  function automatic int follow(int s, logic [5:0] o);
    if (s == 0) return 1;
    if (s == 1) begin
      if (o == C_LW || o == C_SW) return 2;
      if (o == C_RT) return 6;
      if (o == C_BQ) return 8;
      if (o == C_JP) return 9;
      return 0;
    end
    if (s == 2) return (o == C_LW) ? 3 : ((o == C_SW) ? 5 : 0);
    if (s == 3) return 4;
    if (s == 6) return 7;
    return 0;
  endfunction

  function automatic string tag(int s, int p, bit r);
    if (r) return "R1";
    if (p == 1) return (s == 0) ? "R11" : "R4";
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compare();
    logic [15:0] got;
    logic [2:0]  pcx, pce;
    got = {mem_rd_en, mem_wr_en, addr_from_alu, instr_ld_en, pc_wr_en, pc_wr_if_zero,
           pc_src_sel, alu_a_from_reg, alu_b_sel, alu_mode, rf_wr_en,
           rf_data_from_mem, rf_dst_is_rd};
    n_vec++;
    if (step_o != 4'(model) || got != want(model)) begin
      n_bad++;
      $display("FAIL %s step=%0d ctl=%b expected step=%0d ctl=%b",
               tag(model, prior, was_rst), step_o, got, model, want(model));
    end
    // R12: PC-update and address-select outputs against their step sets
    pcx = {pc_wr_en, pc_wr_if_zero, addr_from_alu};
    pce = {(model == 0 || model == 9), (model == 8), (model == 3 || model == 5)};
    n_vec++;
    if (pcx != pce) begin
      n_bad++;
      $display("FAIL R12 pc/addr=%b expected %b at step %0d", pcx, pce, model);
    end
  endtask

  task automatic tick(logic [5:0] o, bit r);
    @(negedge clk);
    opcode = o;
    rst = r;
    @(posedge clk);
    prior = model;
    was_rst = r;
    model = r ? 0 : follow(model, o);
    #1 compare();
  endtask

  task automatic run(logic [5:0] o, int n);
    for (int i = 0; i < n; i++) tick(o, 1'b0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    tick(C_RT, 1'b1);   // R1 reset state
    tick(C_RT, 1'b1);
    run(C_LW, 5);       // R6 load: five cycles
    run(C_SW, 4);       // R7 store: four cycles
    run(C_RT, 4);       // R8 register op
    run(C_BQ, 3);       // R9 branch
    run(C_JP, 3);       // R10 jump
    run(C_XX, 2);       // R11 unknown opcode
    run(6'b000001, 2);  // R11 another unknown
    run(C_LW, 2);       // R5 opcode changes before address step
    tick(C_BQ, 1'b0);
    run(C_RT, 2);       // R1 reset in the middle of an instruction
    tick(C_RT, 1'b1);
    for (int k = 0; k < 3; k++) begin
      run(C_JP, 3);
      run(C_LW, 5);
      run(C_BQ, 3);
      run(C_SW, 4);
      run(C_RT, 4);
    end
    run(C_SW, 3);       // R1 reset from store write step
    tick(C_SW, 1'b1);
    run(C_LW, 5);
    finish_up();
  end

endmodule